// File: doc/BRIEF.md
# Packed 2-Bit Pixel Rectangle Blitter

This block moves a rectangle of 2-bit pixels from one memory to another, four pixels to a byte. Software loads a small register file through a byte-wide write port: control, rectangle size, source and destination start coordinates, a palette, VRAM page selects, a ROM bank and a screen-height setting. It then pulses `start`. The block walks the rectangle one pixel at a time. For each pixel it reads the source byte, reads the destination byte, and writes the destination byte back with only the one 2-bit field changed.

Every copied pixel passes through a four-entry palette. A transparent mode keeps pixel value 0 from overwriting the destination. Four pairings of source and destination memory are supported. Each pairing sets its own line pitch and its own address masking. The memories sit outside the block, behind synchronous read ports and a destination write strobe. A `busy` level covers the transfer and a one-cycle `done` pulse marks its end.

Top module: `pixel_blit`

## Requirements
- R1: Register addresses are 0 control, 1 width, 2 height, 3 source x, 4 source y, 5 destination x, 6 destination y, 7 palette, 8 page, 9 bank, 10 screen height. Control bit 0 set selects opaque mode and clear selects transparent mode. Control bits 2:1 select the pairing: 0 VRAM to VRAM, 1 ROM to VRAM, 2 extended RAM to VRAM, 3 VRAM to extended RAM. Control bit 3 set makes x step down instead of up.
- R2: The pixel in column x of a byte occupies bits (3 - x mod 4)*2 + 1 down to (3 - x mod 4)*2, so column 0 is bits 7:6.
- R3: In transparent mode a source pixel of value 0 leaves the destination byte unchanged. In opaque mode every pixel is written.
- R4: The value written is the palette entry selected by the raw source pixel. Entry k is palette bits 2k+1:2k.
- R5: The byte offset of a pixel is y*pitch + x/4. VRAM uses a pitch of 50 when bit 5 of the screen-height register is 1 and 40 otherwise. ROM and extended RAM always use a pitch of 64.
- R6: A VRAM address is (offset mod 0x2000) + 0x2000*page bit. Page bit 0 applies to a VRAM source and page bit 1 to a VRAM destination. A ROM address is bank*0x4000 + (offset mod 0x4000). An extended-RAM address is the offset unchanged.
- R7: Width value W and height value H move (W+1)*(H+1) pixels. Every row starts again at the programmed start columns, and both y values advance by one per row, wrapping at 8 bits.
- R8: A destination write changes only the target 2-bit field. The other three pixels keep the values just read from that byte.
- R9: Each pixel takes exactly 3 cycles. `busy` is high for 3*(W+1)*(H+1) cycles after the start edge, and `done` is high for exactly the one cycle after `busy` falls.
- R10: While `busy` is high, register writes and `start` pulses have no effect on the current transfer or on the next one.
- R11: Reads are synchronous: data is expected one cycle after `srcRe` or `dstRe`. The select `srcMem` is 0 for VRAM, 1 for ROM and 2 for extended RAM. The select `dstMem` is 0 for VRAM and 1 for extended RAM. A write is preceded by a read of the same address in the previous cycle.
- R12: After reset `busy`, `done`, `srcRe`, `dstRe` and `dstWe` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regData | input | 8 | Register write data |
| start | input | 1 | Start strobe |
| srcAddr | output | 22 | Source byte address |
| srcMem | output | 2 | Source memory select |
| srcRe | output | 1 | Source read enable |
| srcRdata | input | 8 | Source read data, one cycle after srcRe |
| dstAddr | output | 22 | Destination byte address |
| dstMem | output | 1 | Destination memory select |
| dstRe | output | 1 | Destination read enable |
| dstRdata | input | 8 | Destination read data, one cycle after dstRe |
| dstWe | output | 1 | Destination write strobe |
| dstWdata | output | 8 | Destination write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume the memories answer each read one cycle after the enable and return data for the address presented in that enable cycle. The bench memory models do exactly that. The checks on register freezing and on the counter range also assume that software never writes a register in the same cycle as an accepted `start`. The bench always lets at least one idle cycle pass between its last register write and the start pulse.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SRC,
    ST_DST,
    ST_WR
  } blit_state_e;

  typedef struct packed {
    logic load;
    logic srcRd;
    logic dstRd;
    logic wrPhase;
  } blit_cmd_t;

  localparam logic [3:0] RA_CTRL  = 4'd0;
  localparam logic [3:0] RA_WIDTH = 4'd1;
  localparam logic [3:0] RA_HGT   = 4'd2;
  localparam logic [3:0] RA_SX    = 4'd3;
  localparam logic [3:0] RA_SY    = 4'd4;
  localparam logic [3:0] RA_DX    = 4'd5;
  localparam logic [3:0] RA_DY    = 4'd6;
  localparam logic [3:0] RA_PAL   = 4'd7;
  localparam logic [3:0] RA_PAGE  = 4'd8;
  localparam logic [3:0] RA_BANK  = 4'd9;
  localparam logic [3:0] RA_LCD   = 4'd10;

  localparam logic [1:0] MODE_V2V = 2'd0;
  localparam logic [1:0] MODE_R2V = 2'd1;
  localparam logic [1:0] MODE_X2V = 2'd2;
  localparam logic [1:0] MODE_V2X = 2'd3;

  localparam logic [1:0] MEM_VRAM = 2'd0;
  localparam logic [1:0] MEM_ROM  = 2'd1;
  localparam logic [1:0] MEM_XRAM = 2'd2;
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      lastPix,
  output blit_cmd_t cmd,
  output logic      busy,
  output logic      done
);
  blit_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = ST_SRC;
      ST_SRC:  stateNext = ST_DST;
      ST_DST:  stateNext = ST_WR;
      ST_WR:   stateNext = lastPix ? ST_IDLE : ST_SRC;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_WR) && lastPix;
    end
  end

  always_comb begin
    cmd.load    = (state == ST_IDLE) && start;
    cmd.srcRd   = (state == ST_SRC);
    cmd.dstRd   = (state == ST_DST);
    cmd.wrPhase = (state == ST_WR);
  end

  assign busy = (state != ST_IDLE);

  // R9: the end pulse lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: the end pulse follows the busy window directly
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  // R11: source read, destination read and write phases come in order
  a_r11_phase_order: assert property (@(posedge clk) disable iff (!rstN)
    cmd.srcRd |=> cmd.dstRd);
endmodule

// File: rtl/blit_dp.sv
module blit_dp
  import blit_pkg::*;
#(
  parameter int XY_W        = 8,
  parameter int BANK_W      = 8,
  parameter int VRAM_MASK_W = 13,
  parameter int ROM_MASK_W  = 14,
  parameter int PITCH_NARROW = 40,
  parameter int PITCH_WIDE   = 50,
  parameter int PITCH_LINEAR = 64,
  localparam int ADDR_W  = BANK_W + ROM_MASK_W,
  localparam int PITCH_W = $clog2(PITCH_LINEAR + 1),
  localparam int LIN_W   = XY_W + PITCH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regData,
  input  logic              busy,
  input  blit_cmd_t         cmd,
  input  logic [7:0]        srcRdata,
  input  logic [7:0]        dstRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [1:0]        srcMem,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              dstMem,
  output logic [7:0]        dstWdata,
  output logic              dstWe,
  output logic              lastPix
);
  localparam int PIX_PER_BYTE = 4;

  logic [3:0]        cfgCtrl;
  logic [XY_W-1:0]   widthX, widthY, sx0, sy0, dx0, dy0;
  logic [7:0]        pal;
  logic [1:0]        page;
  logic [BANK_W-1:0] bank;
  logic              lcdWide;

  logic [XY_W-1:0]   curSx, curSy, curDx, curDy, xCnt, yCnt;
  logic [1:0]        pixSrc;

  logic       opaque, decX;
  logic [1:0] mode;
  assign opaque = cfgCtrl[0];
  assign mode   = cfgCtrl[2:1];
  assign decX   = cfgCtrl[3];

  logic [1:0] palEnt [PIX_PER_BYTE];
  for (genvar i = 0; i < PIX_PER_BYTE; i++) begin : g_pal
    assign palEnt[i] = pal[2*i +: 2];
  end

  function automatic logic [LIN_W-1:0] lineOff(input logic [XY_W-1:0] y,
                                                input logic [XY_W-1:0] x,
                                                input logic [PITCH_W-1:0] pitch);
    return LIN_W'(y) * LIN_W'(pitch) + LIN_W'(x >> 2);
  endfunction

  function automatic logic [ADDR_W-1:0] vramAddr(input logic [LIN_W-1:0] lin,
                                                 input logic pg);
    return ADDR_W'({pg, lin[VRAM_MASK_W-1:0]});
  endfunction

  logic [PITCH_W-1:0] vramPitch, srcPitch, dstPitch;
  logic [LIN_W-1:0]   srcLin, dstLin;

  always_comb begin
    vramPitch = lcdWide ? PITCH_W'(PITCH_WIDE) : PITCH_W'(PITCH_NARROW);
    srcPitch  = (mode == MODE_V2V || mode == MODE_V2X) ? vramPitch : PITCH_W'(PITCH_LINEAR);
    dstPitch  = (mode == MODE_V2X) ? PITCH_W'(PITCH_LINEAR) : vramPitch;
    srcLin    = lineOff(curSy, curSx, srcPitch);
    dstLin    = lineOff(curDy, curDx, dstPitch);
    case (mode)
      MODE_R2V: begin
        srcAddr = {bank, srcLin[ROM_MASK_W-1:0]};
        srcMem  = MEM_ROM;
      end
      MODE_X2V: begin
        srcAddr = ADDR_W'(srcLin);
        srcMem  = MEM_XRAM;
      end
      default: begin
        srcAddr = vramAddr(srcLin, page[0]);
        srcMem  = MEM_VRAM;
      end
    endcase
    if (mode == MODE_V2X) begin
      dstAddr = ADDR_W'(dstLin);
      dstMem  = 1'b1;
    end else begin
      dstAddr = vramAddr(dstLin, page[1]);
      dstMem  = 1'b0;
    end
  end

  logic [2:0] srcSh, dstSh;
  logic [1:0] pixNow;
  assign srcSh  = {2'd3 - curSx[1:0], 1'b0};
  assign dstSh  = {2'd3 - curDx[1:0], 1'b0};
  assign pixNow = 2'(srcRdata >> srcSh);

  assign dstWe    = cmd.wrPhase && (opaque || pixSrc != 2'd0);
  assign dstWdata = (dstRdata & ~(8'd3 << dstSh)) | ({6'd0, palEnt[pixSrc]} << dstSh);
  assign lastPix  = (xCnt == widthX) && (yCnt == widthY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgCtrl <= '0; widthX <= '0; widthY <= '0;
      sx0 <= '0; sy0 <= '0; dx0 <= '0; dy0 <= '0;
      pal <= '0; page <= '0; bank <= '0; lcdWide <= 1'b0;
      curSx <= '0; curSy <= '0; curDx <= '0; curDy <= '0;
      xCnt <= '0; yCnt <= '0; pixSrc <= '0;
    end else begin
      if (regWe && !busy) begin
        case (regAddr)
          RA_CTRL:  cfgCtrl <= regData[3:0];
          RA_WIDTH: widthX  <= regData[XY_W-1:0];
          RA_HGT:   widthY  <= regData[XY_W-1:0];
          RA_SX:    sx0     <= regData[XY_W-1:0];
          RA_SY:    sy0     <= regData[XY_W-1:0];
          RA_DX:    dx0     <= regData[XY_W-1:0];
          RA_DY:    dy0     <= regData[XY_W-1:0];
          RA_PAL:   pal     <= regData;
          RA_PAGE:  page    <= regData[1:0];
          RA_BANK:  bank    <= regData[BANK_W-1:0];
          RA_LCD:   lcdWide <= regData[5];
          default: ;
        endcase
      end
      if (cmd.load) begin
        curSx <= sx0; curSy <= sy0; curDx <= dx0; curDy <= dy0;
        xCnt  <= '0;  yCnt  <= '0;
      end
      if (cmd.dstRd) pixSrc <= pixNow;
      if (cmd.wrPhase) begin
        if (xCnt == widthX) begin
          xCnt  <= '0;
          yCnt  <= yCnt + 1'b1;
          curSx <= sx0;
          curDx <= dx0;
          curSy <= curSy + 1'b1;
          curDy <= curDy + 1'b1;
        end else begin
          xCnt  <= xCnt + 1'b1;
          curSx <= decX ? curSx - 1'b1 : curSx + 1'b1;
          curDx <= decX ? curDx - 1'b1 : curDx + 1'b1;
        end
      end
    end
  end

  // R8: bits outside the target field are written back as read
  a_r8_keep_other_pixels: assert property (@(posedge clk) disable iff (!rstN)
    dstWe |-> (((dstWdata ^ dstRdata) & ~(8'd3 << dstSh)) == 8'd0));
  // R11: each write follows a read of the destination
  a_r11_read_before_write: assert property (@(posedge clk) disable iff (!rstN)
    dstWe |-> $past(cmd.dstRd));
  // R11: the write goes to the address that was read
  a_r11_dst_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    dstWe |-> $stable(dstAddr));
  // R10: configuration does not move during a transfer
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(cfgCtrl) && $stable(pal) && $stable(widthX) && $stable(widthY)));
  // R7: pixel and row counters stay inside the programmed rectangle
  a_r7_count_range: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (xCnt <= widthX && yCnt <= widthY));
endmodule

// File: rtl/pixel_blit.sv
module pixel_blit
  import blit_pkg::*;
#(
  parameter int XY_W         = 8,
  parameter int BANK_W       = 8,
  parameter int VRAM_MASK_W  = 13,
  parameter int ROM_MASK_W   = 14,
  parameter int PITCH_NARROW = 40,
  parameter int PITCH_WIDE   = 50,
  parameter int PITCH_LINEAR = 64,
  localparam int ADDR_W = BANK_W + ROM_MASK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regData,
  input  logic              start,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [1:0]        srcMem,
  output logic              srcRe,
  input  logic [7:0]        srcRdata,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              dstMem,
  output logic              dstRe,
  input  logic [7:0]        dstRdata,
  output logic              dstWe,
  output logic [7:0]        dstWdata,
  output logic              busy,
  output logic              done
);
  blit_cmd_t cmd;
  logic      lastPix;

  blit_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lastPix(lastPix),
    .cmd(cmd), .busy(busy), .done(done)
  );

  blit_dp #(
    .XY_W(XY_W), .BANK_W(BANK_W), .VRAM_MASK_W(VRAM_MASK_W),
    .ROM_MASK_W(ROM_MASK_W), .PITCH_NARROW(PITCH_NARROW),
    .PITCH_WIDE(PITCH_WIDE), .PITCH_LINEAR(PITCH_LINEAR)
  ) i_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .busy(busy), .cmd(cmd), .srcRdata(srcRdata), .dstRdata(dstRdata),
    .srcAddr(srcAddr), .srcMem(srcMem), .dstAddr(dstAddr), .dstMem(dstMem),
    .dstWdata(dstWdata), .dstWe(dstWe), .lastPix(lastPix)
  );

  assign srcRe = cmd.srcRd;
  assign dstRe = cmd.dstRd;
endmodule

// File: tb/test_pixel_blit.sv
module test_pixel_blit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic start = 1'b0;
  logic [21:0] srcAddr, dstAddr;
  logic [1:0] srcMem;
  logic srcRe, dstRe, dstWe, dstMem, busy, done;
  logic [7:0] srcRdata = '0, dstRdata = '0, dstWdata;

  always #2.5 clk = ~clk;

  pixel_blit i_pixel_blit (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .start(start), .srcAddr(srcAddr), .srcMem(srcMem), .srcRe(srcRe),
    .srcRdata(srcRdata), .dstAddr(dstAddr), .dstMem(dstMem), .dstRe(dstRe),
    .dstRdata(dstRdata), .dstWe(dstWe), .dstWdata(dstWdata), .busy(busy), .done(done)
  );

  int nChecks = 0, nFail = 0, cyc = 0, busyCnt = 0;

  logic [7:0] vramM [int];
  logic [7:0] xramM [int];
  logic [7:0] vramR [int];
  logic [7:0] xramR [int];

  function automatic logic [7:0] initV(int a); return 8'((a * 37) ^ (a >> 5) ^ 8'h5A); endfunction
  function automatic logic [7:0] initX(int a); return 8'((a * 11) + (a >> 7) + 8'h33); endfunction
  function automatic logic [7:0] romB(int a);  return 8'(a ^ ((a >> 8) * 3) ^ ((a >> 14) * 29)); endfunction

  function automatic logic [7:0] dutV(int a); return vramM.exists(a) ? vramM[a] : initV(a); endfunction
  function automatic logic [7:0] dutX(int a); return xramM.exists(a) ? xramM[a] : initX(a); endfunction
  function automatic logic [7:0] refV(int a); return vramR.exists(a) ? vramR[a] : initV(a); endfunction
  function automatic logic [7:0] refX(int a); return xramR.exists(a) ? xramR[a] : initX(a); endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busy) busyCnt <= busyCnt + 1;
    if (srcRe) srcRdata <= (srcMem == 2'd1) ? romB(int'(srcAddr)) :
                           (srcMem == 2'd2) ? dutX(int'(srcAddr)) : dutV(int'(srcAddr));
    if (dstRe) dstRdata <= dstMem ? dutX(int'(dstAddr)) : dutV(int'(dstAddr));
    if (dstWe) begin
      if (dstMem) xramM[int'(dstAddr)] = dstWdata;
      else        vramM[int'(dstAddr)] = dstWdata;
    end
  end

  // configuration mirror
  int cOpaque, cMode, cDec, cW, cH, cSx, cSy, cDx, cDy, cPal, cPage, cBank, cWide;

  task automatic check(bit cond, string msg, int act, int exp);
    nChecks++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finishRun();
  end

  task automatic wrReg(logic [3:0] a, int d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regData = 8'(d);
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic prog();
    wrReg(4'd0, cOpaque | (cMode << 1) | (cDec << 3));
    wrReg(4'd1, cW);  wrReg(4'd2, cH);
    wrReg(4'd3, cSx); wrReg(4'd4, cSy);
    wrReg(4'd5, cDx); wrReg(4'd6, cDy);
    wrReg(4'd7, cPal); wrReg(4'd8, cPage);
    wrReg(4'd9, cBank); wrReg(4'd10, cWide ? 8'h20 : 8'h00);
  endtask

  function automatic int lineOf(int y, int x, int p); return y * p + x / 4; endfunction

  task automatic refRun();
    int pV = cWide ? 50 : 40;
    for (int yc = 0; yc <= cH; yc++) begin
      int sy = (cSy + yc) & 255, dy = (cDy + yc) & 255, sx = cSx, dx = cDx;
      for (int xc = 0; xc <= cW; xc++) begin
        int sa, da, sb, pix, db, so, dof;
        case (cMode)
          1: sa = (cBank << 14) | (lineOf(sy, sx, 64) & 'h3FFF);
          2: sa = lineOf(sy, sx, 64);
          default: sa = (lineOf(sy, sx, pV) & 'h1FFF) + ((cPage & 1) ? 'h2000 : 0);
        endcase
        if (cMode == 3) da = lineOf(dy, dx, 64);
        else da = (lineOf(dy, dx, pV) & 'h1FFF) + ((cPage & 2) ? 'h2000 : 0);
        sb = (cMode == 1) ? romB(sa) : (cMode == 2) ? refX(sa) : refV(sa);
        so = (3 - (sx % 4)) * 2;
        dof = (3 - (dx % 4)) * 2;
        pix = (sb >> so) & 3;
        if (cOpaque != 0 || pix != 0) begin
          db = (cMode == 3) ? refX(da) : refV(da);
          db = (db & ~(3 << dof) & 255) | (((cPal >> (2 * pix)) & 3) << dof);
          if (cMode == 3) xramR[da] = 8'(db); else vramR[da] = 8'(db);
        end
        sx = cDec ? ((sx - 1) & 255) : ((sx + 1) & 255);
        dx = cDec ? ((dx - 1) & 255) : ((dx + 1) & 255);
      end
    end
  endtask

  task automatic cmpMem(string tag);
    bit ok = 1'b1;
    int ba = 0, bd = 0, br = 0;
    foreach (vramM[k]) if (vramM[k] != refV(k)) begin if (ok) begin ba = k; bd = vramM[k]; br = refV(k); end ok = 0; end
    foreach (vramR[k]) if (vramR[k] != dutV(k)) begin if (ok) begin ba = k; bd = dutV(k); br = vramR[k]; end ok = 0; end
    foreach (xramM[k]) if (xramM[k] != refX(k)) begin if (ok) begin ba = k; bd = xramM[k]; br = refX(k); end ok = 0; end
    foreach (xramR[k]) if (xramR[k] != dutX(k)) begin if (ok) begin ba = k; bd = dutX(k); br = xramR[k]; end ok = 0; end
    if (!ok) $display("  mismatch at address %0h", ba);
    check(ok, {tag, " R1 R2 R3 R4 R5 R6 R8 R11 memory contents"}, bd, br);
  endtask

  task automatic run(bit disturb, string tag);
    int c0, guard = 0, nPix;
    vramR = vramM; xramR = xramM;
    refRun();
    nPix = (cW + 1) * (cH + 1);
    @(negedge clk); c0 = busyCnt; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (disturb) begin
      regWe = 1'b1; regAddr = 4'd0; regData = 8'h0F;
      @(negedge clk); regAddr = 4'd7; regData = 8'h00;
      @(negedge clk); regAddr = 4'd1; regData = 8'h00;
      @(negedge clk); regWe = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    check(done && !busy, {tag, " R9 done after busy"}, {done, busy}, 2'b10);
    check(busyCnt - c0 == 3 * nPix, {tag, " R7 R9 busy cycles"}, busyCnt - c0, 3 * nPix);
    @(negedge clk);
    check(!done && !busy, {tag, " R9 R10 done single cycle, no restart"}, {done, busy}, 0);
    cmpMem(tag);
  endtask

  task automatic setCfg(int op, int md, int dc, int w, int h, int sx, int sy,
                        int dx, int dy, int pl, int pg, int bk, int wd);
    cOpaque = op; cMode = md; cDec = dc; cW = w; cH = h; cSx = sx; cSy = sy;
    cDx = dx; cDy = dy; cPal = pl; cPage = pg; cBank = bk; cWide = wd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, srcRe, dstRe, dstWe} == 5'b0, "R12 reset outputs",
          {busy, done, srcRe, dstRe, dstWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, srcRe, dstRe, dstWe} == 5'b0, "R12 idle after reset",
          {busy, done, srcRe, dstRe, dstWe}, 0);

    // R2 R4: one opaque pixel, identity palette, source column 0 into destination column 3
    setCfg(1, 0, 0, 0, 0, 0, 0, 3, 2, 8'hE4, 0, 0, 0);
    vramM[0] = 8'h80; vramM[80] = 8'h00;
    prog(); run(1'b0, "single pixel");
    check(dutV(80) == 8'h02, "R2 R4 column placement", dutV(80), 8'h02);

    // R3: a transparent zero pixel leaves the byte alone
    setCfg(0, 0, 0, 0, 0, 0, 0, 0, 2, 8'hFF, 0, 0, 0);
    vramM[0] = 8'h3F; vramM[80] = 8'hA5;
    prog(); run(1'b0, "transparent zero");
    check(dutV(80) == 8'hA5, "R3 zero pixel skipped", dutV(80), 8'hA5);

    // R3 R4: a transparent nonzero pixel is translated through the palette
    setCfg(0, 0, 0, 0, 0, 1, 0, 0, 2, 8'h40, 0, 0, 0);
    prog(); run(1'b0, "transparent nonzero");
    check(dutV(80) == 8'h65, "R3 R4 nonzero pixel written", dutV(80), 8'h65);

    // Sweep over pairings, modes, x direction and geometries
    for (int m = 0; m < 4; m++)
      for (int ov = 0; ov < 2; ov++)
        for (int dc = 0; dc < 2; dc++)
          for (int g = 0; g < 3; g++) begin
            setCfg(ov, m, dc, (g * 4 + m + ov) % 8, (g + dc) % 3,
                   (g * 13 + m * 3 + 250 * dc) & 255, g * 7 + m,
                   (g * 9 + ov * 5 + 1) & 255, g * 11 + 3,
                   (27 + m * 53 + g * 71 + ov * 17) & 255, (m + g) & 3,
                   (g * 3 + m + 1) & 255, g & 1);
            prog();
            run(1'b0, $sformatf("sweep mode=%0d opq=%0d dec=%0d g=%0d", m, ov, dc, g));
          end

    // R10: writes and start while busy are ignored, now and in the following run
    setCfg(0, 2, 0, 3, 1, 5, 9, 2, 4, 8'hC6, 2, 0, 1);
    prog();
    run(1'b1, "R10 writes while busy");
    run(1'b0, "R10 rerun with same registers");

    finishRun();
  end
endmodule